// File: doc/BRIEF.md
# DRAM Row Refresh Sequencer

This block keeps the charge of every row in a group of DRAM banks restored within a fixed retention window. It hands out refresh work as a stream of requests to the command arbiter. Each request names a row and a bank, and says whether the step is the row activate or the closing precharge. The arbiter answers with a one-cycle grant. From the moment the block asks for a bank until the precharge of that bank has settled, the block raises that bank's busy line. The scheduler must not issue normal accesses to a bank whose busy line is high.

Refresh work is counted in slots. One slot refreshes one row index in every bank of the group, in ascending bank order. After a slot the row index moves on, and it wraps to 0 after the last row. The retention period is split into equal intervals, one interval per row. A mode input picks when slots are earned. In distributed mode one slot is earned at the end of every interval, so pauses stay short. In burst mode a whole period's worth of slots (one per row) is earned at each period boundary, and they are served back to back.

Slots that cannot be served at once are kept in a pending count. A slow arbiter therefore delays refresh but never makes the block skip a row. The pending count is capped.

Top module: `refresh_ctrl`

## Requirements
- R1: After reset, reqValid is 0, every bankBusy bit is 0, and reqRow and reqBank are both 0.
- R2: The interval is PERIOD_CYC/ROWS cycles. The first slot is earned when the interval counter expires, one full interval after reset. The first request then appears on the following cycle.
- R3: A slot issues requests for the same row in banks 0, 1 … BANKS-1 in that order. The row index then increments and wraps from ROWS-1 to 0.
- R4: Each bank operation has four phases, in this order:
  1. An activate request with reqIsPre=0.
  2. After its grant, exactly ACT_HOLD cycles with no request.
  3. A precharge request with reqIsPre=1.
  4. After its grant, exactly PRE_HOLD cycles with no request.
  One idle cycle then follows before the next operation.
- R5: bankBusy is one-hot on reqBank from the first cycle of the activate request through the last PRE_HOLD cycle. Otherwise it is all zero. bankBusy bit i belongs to bank i.
- R6: While grant is low, a pending request keeps reqValid, reqIsPre, reqRow and reqBank unchanged. No row or bank is skipped.
- R7: With burstMode=1, each period boundary (after ROWS intervals) adds ROWS slots to the pending count. These are served back to back.
- R8: With burstMode=0, each interval end adds one slot. Slots that are not yet served wait and are served later in order.
- R9: The pending slot count saturates at 2*ROWS-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstMode | input | 1 | 1 = burst refresh at period boundaries, 0 = one slot per interval |
| grant | input | 1 | Arbiter accepts the current request on this cycle |
| reqValid | output | 1 | A refresh command request is pending |
| reqIsPre | output | 1 | 0 = activate, 1 = precharge |
| reqRow | output | $clog2(ROWS) | Row index being refreshed |
| reqBank | output | $clog2(BANKS) | Bank index being refreshed |
| bankBusy | output | BANKS | Per-bank busy line toward the scheduler |

## Verification
The bench builds the block with ROWS=8, BANKS=2, PERIOD_CYC=256, ACT_HOLD=2 and PRE_HOLD=1, which gives an interval of 32 cycles. With these values the run reaches many row wraps, both modes, several burst period boundaries and a grant starvation long enough to saturate the pending count at 15. The run stays within a few thousand cycles. A behavioural model predicts every output on every cycle. Directed counts of granted activates over fixed windows confirm the slot rate in each mode.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT_REQ,
    PH_ACT_WAIT,
    PH_PRE_REQ,
    PH_PRE_WAIT
  } refPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadActHold;
    logic loadPreHold;
    logic countHold;
    logic finishOp;
  } refStrobe_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int ROWS       = 16384,
  parameter int BANKS      = 4,
  parameter int PERIOD_CYC = 51200000,
  parameter int ACT_HOLD   = 12,
  parameter int PRE_HOLD   = 5,
  localparam int RW = $clog2(ROWS),
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          burstMode,
  input  refStrobe_t    strobe,
  output logic          creditAvail,
  output logic          holdZero,
  output logic [RW-1:0] rowIdx,
  output logic [BW-1:0] bankIdx
);

  localparam int INTERVAL = PERIOD_CYC / ROWS;
  localparam int IW       = $clog2(INTERVAL + 1);
  localparam int CW       = $clog2(2 * ROWS);
  localparam int CMAX     = 2 * ROWS - 1;
  localparam int HMAX     = (ACT_HOLD > PRE_HOLD) ? ACT_HOLD : PRE_HOLD;
  localparam int HW       = $clog2(HMAX + 1);

  logic [IW-1:0] intervalQ;
  logic [RW-1:0] slotQ;
  logic [RW-1:0] rowQ;
  logic [BW-1:0] bankQ;
  logic [CW-1:0] creditQ;
  logic [CW-1:0] creditNext;
  logic [HW-1:0] holdQ;
  logic          tick;
  logic          periodTick;
  logic          lastBank;
  logic          consume;
  logic [CW:0]   addAmt;
  logic [CW:0]   sumRaw;

  assign tick       = (intervalQ == IW'(INTERVAL - 1));
  assign periodTick = tick && (slotQ == RW'(ROWS - 1));
  assign consume    = strobe.finishOp && lastBank;

  // interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     intervalQ <= '0;
    else if (tick) intervalQ <= '0;
    else           intervalQ <= intervalQ + 1'b1;
  end

  // interval index inside the period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= '0;
    else if (tick) begin
      if (slotQ == RW'(ROWS - 1)) slotQ <= '0;
      else                        slotQ <= slotQ + 1'b1;
    end
  end

  // slot credit accounting
  always_comb begin
    if (burstMode) addAmt = periodTick ? (CW+1)'(ROWS) : '0;
    else           addAmt = tick ? (CW+1)'(1) : '0;
    sumRaw = {1'b0, creditQ} + addAmt - {{CW{1'b0}}, consume};
    if (sumRaw > (CW+1)'(CMAX)) creditNext = CW'(CMAX);
    else                        creditNext = sumRaw[CW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) creditQ <= '0;
    else       creditQ <= creditNext;
  end

  // row pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowQ <= '0;
    else if (consume) begin
      if (rowQ == RW'(ROWS - 1)) rowQ <= '0;
      else                       rowQ <= rowQ + 1'b1;
    end
  end

  // bank pointer, variant picked by bank count
  generate
    if (BANKS == 1) begin : g_single_bank
      assign lastBank = 1'b1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bankQ <= '0;
        else       bankQ <= '0;
      end
    end else begin : g_multi_bank
      assign lastBank = (bankQ == BW'(BANKS - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bankQ <= '0;
        else if (strobe.finishOp) begin
          if (lastBank) bankQ <= '0;
          else          bankQ <= bankQ + 1'b1;
        end
      end
    end
  endgenerate

  // activate / precharge settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdQ <= '0;
    else if (strobe.loadActHold) holdQ <= HW'(ACT_HOLD - 1);
    else if (strobe.loadPreHold) holdQ <= HW'(PRE_HOLD - 1);
    else if (strobe.countHold)   holdQ <= holdQ - 1'b1;
  end

  assign creditAvail = (creditQ != '0);
  assign holdZero    = (holdQ == '0);
  assign rowIdx      = rowQ;
  assign bankIdx     = bankQ;

  // R9: a saturated count stays put unless a slot completes
  a_r9_no_overflow : assert property (@(posedge clk) disable iff (!rstN)
    (creditQ == CW'(CMAX) && !consume) |=> (creditQ == CW'(CMAX)));

  // R3: row wraps to 0 after the last row
  a_r3_row_wrap : assert property (@(posedge clk) disable iff (!rstN)
    (consume && rowQ == RW'(ROWS - 1)) |=> (rowQ == '0));

  // R8: one credit per interval in distributed mode
  a_r8_one_per_tick : assert property (@(posedge clk) disable iff (!rstN)
    (!burstMode && tick && !consume && creditQ < CW'(CMAX))
      |=> (creditQ == $past(creditQ) + 1'b1));

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       grant,
  input  logic       creditAvail,
  input  logic       holdZero,
  output refStrobe_t strobe,
  output logic       reqValid,
  output logic       reqIsPre,
  output logic       ownsBank
);

  refPhase_e phaseQ;
  refPhase_e phaseNext;

  always_comb begin
    phaseNext = phaseQ;
    strobe    = '0;
    unique case (phaseQ)
      PH_IDLE: if (creditAvail) phaseNext = PH_ACT_REQ;
      PH_ACT_REQ: if (grant) begin
        phaseNext          = PH_ACT_WAIT;
        strobe.loadActHold = 1'b1;
      end
      PH_ACT_WAIT: begin
        if (holdZero) phaseNext = PH_PRE_REQ;
        else          strobe.countHold = 1'b1;
      end
      PH_PRE_REQ: if (grant) begin
        phaseNext          = PH_PRE_WAIT;
        strobe.loadPreHold = 1'b1;
      end
      PH_PRE_WAIT: begin
        if (holdZero) begin
          phaseNext       = PH_IDLE;
          strobe.finishOp = 1'b1;
        end else begin
          strobe.countHold = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseNext;
  end

  assign reqValid = (phaseQ == PH_ACT_REQ) || (phaseQ == PH_PRE_REQ);
  assign reqIsPre = (phaseQ == PH_PRE_REQ);
  assign ownsBank = (phaseQ != PH_IDLE);

  // R6: an ungranted request keeps its kind
  a_r6_hold_request : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !grant) |=> (reqValid && $stable(reqIsPre)));

  // R4: the precharge request follows the activate settle time
  a_r4_pre_follows_act : assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_ACT_WAIT && holdZero) |=> (reqValid && reqIsPre));

  // R4: a granted precharge is never followed directly by a request
  a_r4_pre_settles : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsPre && grant) |=> !reqValid);

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int ROWS       = 16384,
  parameter int BANKS      = 4,
  parameter int PERIOD_CYC = 51200000,
  parameter int ACT_HOLD   = 12,
  parameter int PRE_HOLD   = 5,
  localparam int RW = $clog2(ROWS),
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstMode,
  input  logic             grant,
  output logic             reqValid,
  output logic             reqIsPre,
  output logic [RW-1:0]    reqRow,
  output logic [BW-1:0]    reqBank,
  output logic [BANKS-1:0] bankBusy
);

  refStrobe_t strobe;
  logic       creditAvail;
  logic       holdZero;
  logic       ownsBank;

  refresh_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .grant       (grant),
    .creditAvail (creditAvail),
    .holdZero    (holdZero),
    .strobe      (strobe),
    .reqValid    (reqValid),
    .reqIsPre    (reqIsPre),
    .ownsBank    (ownsBank)
  );

  refresh_datapath #(
    .ROWS       (ROWS),
    .BANKS      (BANKS),
    .PERIOD_CYC (PERIOD_CYC),
    .ACT_HOLD   (ACT_HOLD),
    .PRE_HOLD   (PRE_HOLD)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .burstMode   (burstMode),
    .strobe      (strobe),
    .creditAvail (creditAvail),
    .holdZero    (holdZero),
    .rowIdx      (reqRow),
    .bankIdx     (reqBank)
  );

  // per-bank busy decode
  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_busy
      assign bankBusy[b] = ownsBank && (reqBank == BW'(b));
    end
  endgenerate

  // R5: a pending request always marks its own bank busy
  a_r5_busy_owner : assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (bankBusy[reqBank] && $countones(bankBusy) == 1));

  // R6: row and bank stay put while the arbiter holds off
  a_r6_stable_target : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !grant) |=> ($stable(reqRow) && $stable(reqBank)));

  // R5: busy drops only after the precharge settle window
  a_r5_busy_release : assert property (@(posedge clk) disable iff (!rstN)
    ($fell(|bankBusy)) |-> !reqValid);

endmodule

// File: tb/refresh_ctrl_tb.sv
module refresh_ctrl_tb_top;

  localparam int ROWS       = 8;
  localparam int BANKS      = 2;
  localparam int PERIOD_CYC = 256;
  localparam int ACT_HOLD   = 2;
  localparam int PRE_HOLD   = 1;
  localparam int INTERVAL   = PERIOD_CYC / ROWS;
  localparam int RW         = $clog2(ROWS);
  localparam int BW         = $clog2(BANKS);

  logic             clk = 1'b0;
  logic             rstN;
  logic             burstMode;
  logic             grant;
  logic             reqValid;
  logic             reqIsPre;
  logic [RW-1:0]    reqRow;
  logic [BW-1:0]    reqBank;
  logic [BANKS-1:0] bankBusy;

  always #10 clk = ~clk;

  refresh_ctrl #(
    .ROWS(ROWS), .BANKS(BANKS), .PERIOD_CYC(PERIOD_CYC),
    .ACT_HOLD(ACT_HOLD), .PRE_HOLD(PRE_HOLD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .grant(grant),
    .reqValid(reqValid), .reqIsPre(reqIsPre), .reqRow(reqRow),
    .reqBank(reqBank), .bankBusy(bankBusy)
  );

  int checks = 0;
  int fails  = 0;

  // reference model: phase 0 idle, 1 act ask, 2 act settle, 3 pre ask, 4 pre settle
  int mTime, mSlot, mCred, mPh, mHold, mRow, mBank;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTime = 0; mSlot = 0; mCred = 0; mPh = 0; mHold = 0; mRow = 0; mBank = 0;
    end else begin
      automatic bit tk  = (mTime == INTERVAL - 1);
      automatic bit ptk = tk && (mSlot == ROWS - 1);
      automatic int add = burstMode ? (ptk ? ROWS : 0) : (tk ? 1 : 0);
      automatic int fin = (mPh == 4 && mHold == 0 && mBank == BANKS - 1) ? 1 : 0;
      automatic int sum = mCred + add - fin;
      if (sum > 2 * ROWS - 1) sum = 2 * ROWS - 1;
      case (mPh)
        0: if (mCred > 0) mPh = 1;
        1: if (grant) begin mPh = 2; mHold = ACT_HOLD - 1; end
        2: if (mHold == 0) mPh = 3; else mHold = mHold - 1;
        3: if (grant) begin mPh = 4; mHold = PRE_HOLD - 1; end
        4: if (mHold == 0) begin
             mPh = 0;
             if (mBank == BANKS - 1) begin
               mBank = 0;
               mRow  = (mRow == ROWS - 1) ? 0 : mRow + 1;
             end else mBank = mBank + 1;
           end else mHold = mHold - 1;
        default: mPh = 0;
      endcase
      mTime = tk ? 0 : mTime + 1;
      if (tk) mSlot = (mSlot == ROWS - 1) ? 0 : mSlot + 1;
      mCred = sum;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // grant policy: 0 always, 1 pseudo-random, 2 never
  int       grantMode = 0;
  bit [15:0] lfsr = 16'hACE1;
  int       actGrants = 0;

  task automatic step();
    int expValid, expPre, expBusy;
    @(negedge clk);
    expValid = (mPh == 1 || mPh == 3) ? 1 : 0;
    expPre   = (mPh == 3) ? 1 : 0;
    expBusy  = (mPh != 0) ? (1 << mBank) : 0;
    check(int'(reqValid) == expValid, "R2/R8 reqValid", int'(reqValid), expValid);
    check(int'(reqIsPre) == expPre,   "R4 reqIsPre",    int'(reqIsPre), expPre);
    check(int'(reqRow) == mRow,       "R3 reqRow",      int'(reqRow),   mRow);
    check(int'(reqBank) == mBank,     "R3 reqBank",     int'(reqBank),  mBank);
    check(int'(bankBusy) == expBusy,  "R5 bankBusy",    int'(bankBusy), expBusy);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (grantMode)
      0: grant = 1'b1;
      1: grant = (lfsr[1:0] != 2'b00);
      default: grant = 1'b0;
    endcase
    if (reqValid && !reqIsPre && grant) actGrants++;
  endtask

  task automatic doReset(input bit mode);
    burstMode = mode;
    grant     = 1'b1;
    rstN      = 1'b0;
    repeat (3) @(negedge clk);
    check(reqValid == 1'b0,  "R1 reqValid after reset", int'(reqValid), 0);
    check(bankBusy == '0,    "R1 bankBusy after reset", int'(bankBusy), 0);
    check(reqRow == '0,      "R1 reqRow after reset",   int'(reqRow),   0);
    check(reqBank == '0,     "R1 reqBank after reset",  int'(reqBank),  0);
    rstN = 1'b1;
    actGrants = 0;
  endtask

  initial begin
    // R2 R8: distributed mode, ten intervals give ten slots
    grantMode = 0;
    doReset(1'b0);
    repeat (10 * INTERVAL + 24) step();
    check(actGrants == 10 * BANKS, "R8 activates in 10 intervals", actGrants, 10 * BANKS);

    // R6: irregular grants
    grantMode = 1;
    repeat (600) step();

    // R9 R6: starvation saturates the backlog, then it drains
    grantMode = 2;
    repeat (700) step();
    grantMode = 0;
    repeat (700) step();

    // R7: burst mode, two period boundaries
    grantMode = 0;
    doReset(1'b1);
    repeat (2 * PERIOD_CYC + 150) step();
    check(actGrants == 2 * ROWS * BANKS, "R7 activates over two bursts",
          actGrants, 2 * ROWS * BANKS);

    // R7 R6: burst with irregular grants
    grantMode = 1;
    repeat (1500) step();

    // R8: back to distributed without reset
    burstMode = 1'b0;
    repeat (800) step();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule